// File: doc/BRIEF.md
# Interleaved Slot Scheduler with Operand Address Generation

This block sequences several independent multi-word computations through one shared pipeline. Time is divided into slot periods of `s` clock cycles. Consecutive periods belong to slots 0, 1, …, σ−1 in turn, and the order then repeats. The active width mode sets both `s` and σ. Mode 0 uses s = 2 and σ = 3. Mode 1 uses s = 3 and σ = 2. In each period the scheduler does one of two things. If the current slot is free, it offers it for a new job. If the slot is busy, it runs one outer iteration of that slot's job and drives the operand read addresses for that iteration.

Per-slot state sits in rotating registers that hold one entry per slot. These are the occupancy flag, the outer-iteration count, the base address and the A-word pointer. Entry 0 always belongs to the current slot. At each period boundary the active σ entries rotate by one place. The control strobes for the arithmetic datapath are fixed-delay copies of scheduler events.

The controller is a three-state machine:
- **SETUP** loads the mode and initialises the slot bases. It moves to RUN when the setup request drops.
- **RUN** offers free slots. When the setup request is seen on the last word of a period, it moves to DRAIN.
- **DRAIN** offers nothing and lets the jobs already accepted finish. It moves to SETUP once no slot is occupied.

Top module: `slot_sched`

## Requirements
- R1: After reset the block is in SETUP. `slot_avail_o`, `write_en_o` and all five strobes are low. The mode is taken from `mode_i` only while in SETUP.
- R2: In RUN and DRAIN, a slot period lasts s cycles (2 in mode 0, 3 in mode 1). Periods visit slots 0..σ−1 cyclically (σ = 3 in mode 0, 2 in mode 1), starting with slot 0 on entry to RUN. `slot_avail_o` is high during a RUN period whose slot was free when the previous period ended, and stays high until a start is taken.
- R3: `start_i` sampled high while `slot_avail_o` is high books the current slot. One cycle later `write_en_o` pulses for one cycle and `slot_avail_o` falls.
- R4: `start_i` while `slot_avail_o` is low is ignored: no `write_en_o` pulse follows.
- R5: A booked slot runs s outer iterations, one on each of its next s visits. On the last one the slot is released and is offered again at its following visit. Every booked job produces exactly one `data_avail_o` pulse.
- R6: Slot i has base address 2·s·i. While `write_en_o` is high, `wr_base_o` carries the base of the booked slot.
- R7: During the period of outer iteration j of a slot, `a_addr_o` = base + j. On word w of that period, `b_addr_o` = base + s + w.
- R8: `rst_t_o` is `write_en_o` delayed by L_MEM+4 cycles.
- R9: Let the compute event be the first cycle of a busy slot's period. `l2_en_o` is that event delayed by L_MEM+4 cycles. `l3_en_o` is `l2_en_o` delayed by a further L_Q+4 cycles.
- R10: `data_avail_o` is the compute event of a slot's final iteration delayed by L_MEM+3+ALPHA cycles.
- R11: `rst_d_o` is the first compute event after each SETUP, delayed by 1+L_MEM+L_L1 cycles. Later compute events produce no `rst_d_o`.
- R12: A setup request during RUN takes effect at the end of the current period. From then on no slot is offered, but jobs already booked complete. A new mode takes effect only after SETUP is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| setup_i | input | 1 | Request for the setup phase |
| mode_i | input | 1 | Width mode, loaded in SETUP |
| start_i | input | 1 | Request for a new job |
| slot_avail_o | output | 1 | Current slot can be booked |
| write_en_o | output | 1 | Operand store strobe |
| wr_base_o | output | ADDR_W | Base address of the booked slot |
| a_addr_o | output | ADDR_W | A-word read address |
| b_addr_o | output | ADDR_W | B-word read address |
| rst_t_o | output | 1 | Delayed clear of the partial result |
| rst_d_o | output | 1 | Delayed clear of the inter-slot carry |
| l2_en_o | output | 1 | Delayed quotient-stage start |
| l3_en_o | output | 1 | Delayed reduction-stage start |
| data_avail_o | output | 1 | Delayed result-ready strobe |

## Verification
The bench runs a cycle-level model of the slot rotation in both modes. It applies three start patterns:
- A saturating burst fills every slot and offers many starts that must be rejected.
- A sparse pattern leaves gaps, which shows whether freed slots are offered again at the right visit.
- A periodic pattern in mode 1 checks the longer period and the shorter ring.

Setup requests arrive while jobs are still in flight, and the mode input is changed during the drain. These cases separate a correct drain from one that drops jobs or applies the new mode early. Every delayed strobe is compared against an event history, so an off-by-one delay shows up in the cycle where it occurs.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        ST_SETUP = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sched_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slot_delay.sv
module slot_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    logic sh_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sh_q[i] <= 1'b0;
        end else begin
            sh_q[0] <= in_i;
            for (int i = 1; i < DEPTH; i++) sh_q[i] <= sh_q[i-1];
        end
    end

    assign out_o = sh_q[DEPTH-1];
endmodule

// File: rtl/slot_cadence.sv
module slot_cadence #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] wd_o,
    output logic             last_wd_o,
    output logic             first_wd_o
);
    logic [CNT_W-1:0] wd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wd_q <= '0;
        else if (!en_i)          wd_q <= '0;
        else if (wd_q == last_i) wd_q <= '0;
        else                     wd_q <= wd_q + 1'b1;
    end

    assign wd_o       = wd_q;
    assign last_wd_o  = en_i && (wd_q == last_i);
    assign first_wd_o = en_i && (wd_q == '0);

    assert_word_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (wd_q <= last_i));
endmodule

// File: rtl/slot_ring.sv
module slot_ring #(
    parameter int MAX_SIG = 3,
    parameter int CNT_W   = 2,
    parameter int ADDR_W  = 5,
    parameter int SIG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [ADDR_W-1:0] init_s_i,
    input  logic [SIG_W-1:0]  sig_i,
    input  logic [CNT_W-1:0]  last_cnt_i,
    input  logic              rotate_i,
    input  logic              accept_i,
    input  logic              step_i,
    output logic              occ_cur_o,
    output logic              occ_next_o,
    output logic              any_occ_o,
    output logic              last_iter_o,
    output logic [ADDR_W-1:0] aptr_cur_o,
    output logic [ADDR_W-1:0] base_cur_o
);
    logic              occ_q  [MAX_SIG];
    logic [CNT_W-1:0]  iter_q [MAX_SIG];
    logic [ADDR_W-1:0] aptr_q [MAX_SIG];
    logic [ADDR_W-1:0] base_q [MAX_SIG];
    logic              occ_d  [MAX_SIG];
    logic [CNT_W-1:0]  iter_d [MAX_SIG];
    logic [ADDR_W-1:0] aptr_d [MAX_SIG];
    logic [ADDR_W-1:0] base_d [MAX_SIG];

    logic              occ_u;
    logic [CNT_W-1:0]  iter_u;
    logic [ADDR_W-1:0] aptr_u;
    logic              fin;

    assign fin = (iter_q[0] == last_cnt_i);

    // updated view of the current slot (entry 0)
    always_comb begin
        occ_u  = occ_q[0];
        iter_u = iter_q[0];
        aptr_u = aptr_q[0];
        if (accept_i) begin
            occ_u  = 1'b1;
            iter_u = '0;
            aptr_u = base_q[0];
        end else if (step_i) begin
            if (fin) begin
                occ_u  = 1'b0;
                iter_u = '0;
            end else begin
                iter_u = iter_q[0] + 1'b1;
                aptr_u = aptr_q[0] + 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < MAX_SIG; i++) begin
            if (init_i) begin
                occ_d[i]  = 1'b0;
                iter_d[i] = '0;
                base_d[i] = ADDR_W'(2 * i) * init_s_i;
                aptr_d[i] = ADDR_W'(2 * i) * init_s_i;
            end else if (rotate_i && (i < int'(sig_i) - 1)) begin
                occ_d[i]  = occ_q [(i == MAX_SIG-1) ? i : i + 1];
                iter_d[i] = iter_q[(i == MAX_SIG-1) ? i : i + 1];
                aptr_d[i] = aptr_q[(i == MAX_SIG-1) ? i : i + 1];
                base_d[i] = base_q[(i == MAX_SIG-1) ? i : i + 1];
            end else if (rotate_i && (i == int'(sig_i) - 1)) begin
                occ_d[i]  = occ_u;
                iter_d[i] = iter_u;
                aptr_d[i] = aptr_u;
                base_d[i] = base_q[0];
            end else if (!rotate_i && i == 0) begin
                occ_d[i]  = occ_u;
                iter_d[i] = iter_u;
                aptr_d[i] = aptr_u;
                base_d[i] = base_q[0];
            end else begin
                occ_d[i]  = occ_q[i];
                iter_d[i] = iter_q[i];
                aptr_d[i] = aptr_q[i];
                base_d[i] = base_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_SIG; i++) begin
                occ_q[i]  <= 1'b0;
                iter_q[i] <= '0;
                aptr_q[i] <= '0;
                base_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < MAX_SIG; i++) begin
                occ_q[i]  <= occ_d[i];
                iter_q[i] <= iter_d[i];
                aptr_q[i] <= aptr_d[i];
                base_q[i] <= base_d[i];
            end
        end
    end

    always_comb begin
        any_occ_o = 1'b0;
        for (int i = 0; i < MAX_SIG; i++) any_occ_o = any_occ_o | occ_q[i];
    end

    assign occ_cur_o   = occ_q[0];
    assign occ_next_o  = occ_q[1];
    assign last_iter_o = fin;
    assign aptr_cur_o  = aptr_q[0];
    assign base_cur_o  = base_q[0];

    assert_book_free_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> !occ_q[0]);
    assert_end_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && fin) |-> occ_q[0]);
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import sched_pkg::*;
#(
    parameter int S_M0   = 2,
    parameter int SIG_M0 = 3,
    parameter int S_M1   = 3,
    parameter int SIG_M1 = 2,
    parameter int L_MEM  = 1,
    parameter int L_Q    = 1,
    parameter int L_L1   = 2,
    parameter int ALPHA  = 6,
    localparam int MAX_S   = max2(S_M0, S_M1),
    localparam int MAX_SIG = max2(SIG_M0, SIG_M1),
    localparam int CNT_W   = (MAX_S > 2) ? $clog2(MAX_S) : 1,
    localparam int SIG_W   = $clog2(MAX_SIG + 1),
    localparam int ADDR_W  = $clog2(2 * MAX_S * MAX_SIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_i,
    input  logic              mode_i,
    input  logic              start_i,
    output logic              slot_avail_o,
    output logic              write_en_o,
    output logic [ADDR_W-1:0] wr_base_o,
    output logic [ADDR_W-1:0] a_addr_o,
    output logic [ADDR_W-1:0] b_addr_o,
    output logic              rst_t_o,
    output logic              rst_d_o,
    output logic              l2_en_o,
    output logic              l3_en_o,
    output logic              data_avail_o
);
    localparam int D_RST_T = L_MEM + 4;
    localparam int D_L2    = L_MEM + 4;
    localparam int D_L3    = L_Q + 4;
    localparam int D_DAV   = L_MEM + 3 + ALPHA;
    localparam int D_RST_D = 1 + L_MEM + L_L1;

    sched_state_e      state_q, state_d;
    logic              mode_q;
    logic              avail_q, cur_comp_q, first_pend_q, we_q;
    logic [ADDR_W-1:0] wr_base_q;

    logic [CNT_W-1:0]  last_cnt, wd;
    logic [SIG_W-1:0]  sig_act;
    logic [ADDR_W-1:0] s_addr, init_s;
    logic              run_act, last_wd, first_wd, accept, step, comp_en;
    logic              occ_cur, occ_next, any_occ, last_iter;
    logic [ADDR_W-1:0] aptr_cur, base_cur;

    assign last_cnt = mode_q ? CNT_W'(S_M1 - 1) : CNT_W'(S_M0 - 1);
    assign sig_act  = mode_q ? SIG_W'(SIG_M1) : SIG_W'(SIG_M0);
    assign s_addr   = mode_q ? ADDR_W'(S_M1) : ADDR_W'(S_M0);
    assign init_s   = mode_i ? ADDR_W'(S_M1) : ADDR_W'(S_M0);
    assign run_act  = (state_q != ST_SETUP);
    assign accept   = avail_q && start_i;
    assign step     = last_wd && cur_comp_q;
    assign comp_en  = first_wd && cur_comp_q;

    slot_cadence #(.CNT_W(CNT_W)) u_cad (
        .clk(clk), .rst_n(rst_n), .en_i(run_act), .last_i(last_cnt),
        .wd_o(wd), .last_wd_o(last_wd), .first_wd_o(first_wd)
    );

    slot_ring #(.MAX_SIG(MAX_SIG), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .init_i(state_q == ST_SETUP), .init_s_i(init_s),
        .sig_i(sig_act), .last_cnt_i(last_cnt), .rotate_i(last_wd),
        .accept_i(accept), .step_i(step),
        .occ_cur_o(occ_cur), .occ_next_o(occ_next), .any_occ_o(any_occ),
        .last_iter_o(last_iter), .aptr_cur_o(aptr_cur), .base_cur_o(base_cur)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETUP: if (!setup_i)            state_d = ST_RUN;
            ST_RUN:   if (last_wd && setup_i)  state_d = ST_DRAIN;
            ST_DRAIN: if (!any_occ)            state_d = ST_SETUP;
            default:                           state_d = ST_SETUP;
        endcase
    end

    // registered outputs and per-phase flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= 1'b0;
            avail_q      <= 1'b0;
            cur_comp_q   <= 1'b0;
            first_pend_q <= 1'b1;
            we_q         <= 1'b0;
            wr_base_q    <= '0;
        end else begin
            we_q <= accept;
            if (accept) wr_base_q <= base_cur;
            unique case (state_q)
                ST_SETUP: begin
                    mode_q       <= mode_i;
                    avail_q      <= !setup_i;
                    cur_comp_q   <= 1'b0;
                    first_pend_q <= 1'b1;
                end
                ST_RUN: begin
                    if (comp_en) first_pend_q <= 1'b0;
                    if (last_wd) begin
                        avail_q    <= !setup_i && !occ_next;
                        cur_comp_q <= occ_next;
                    end else if (accept) begin
                        avail_q <= 1'b0;
                    end
                end
                ST_DRAIN: begin
                    if (comp_en) first_pend_q <= 1'b0;
                    avail_q <= 1'b0;
                    if (last_wd) cur_comp_q <= occ_next;
                end
                default: avail_q <= 1'b0;
            endcase
        end
    end

    slot_delay #(.DEPTH(D_RST_T)) u_d_rst_t (.clk(clk), .rst_n(rst_n), .in_i(we_q), .out_o(rst_t_o));
    slot_delay #(.DEPTH(D_L2)) u_d_l2 (.clk(clk), .rst_n(rst_n), .in_i(comp_en), .out_o(l2_en_o));
    slot_delay #(.DEPTH(D_L3)) u_d_l3 (.clk(clk), .rst_n(rst_n), .in_i(l2_en_o), .out_o(l3_en_o));
    slot_delay #(.DEPTH(D_DAV)) u_d_dav (.clk(clk), .rst_n(rst_n),
        .in_i(comp_en && last_iter), .out_o(data_avail_o));
    slot_delay #(.DEPTH(D_RST_D)) u_d_rst_d (.clk(clk), .rst_n(rst_n),
        .in_i(comp_en && first_pend_q), .out_o(rst_d_o));

    assign slot_avail_o = avail_q;
    assign write_en_o   = we_q;
    assign wr_base_o    = wr_base_q;
    assign a_addr_o     = aptr_cur;
    assign b_addr_o     = base_cur + s_addr + ADDR_W'(wd);

    assert_avail_only_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_avail_o |-> (state_q == ST_RUN));
    assert_write_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_avail_o && start_i) |=> write_en_o);
    assert_no_write_unoffered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        write_en_o |-> $past(slot_avail_o && start_i));
    assert_busy_slot_not_offered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_avail_o |-> !occ_cur || write_en_o || !$stable(occ_cur));
    assert_mode_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SETUP) |=> $stable(mode_q));
endmodule

// File: tb/tb_slot_sched.sv
`timescale 1ns/1ps
module tb_slot_sched;
    localparam int LMEM = 1, LQ = 1, LL1 = 2, ALP = 6;
    localparam int D_RT = LMEM + 4, D_L2 = LMEM + 4, D_L3 = D_L2 + LQ + 4;
    localparam int D_DAV = LMEM + 3 + ALP, D_RD = 1 + LMEM + LL1;

    logic clk = 0, rst_n = 0, setup_i = 1, mode_i = 0, start_i = 0;
    logic slot_avail_o, write_en_o, rst_t_o, rst_d_o, l2_en_o, l3_en_o, data_avail_o;
    logic [4:0] wr_base_o, a_addr_o, b_addr_o;

    slot_sched #(.S_M0(2), .SIG_M0(3), .S_M1(3), .SIG_M1(2),
                 .L_MEM(LMEM), .L_Q(LQ), .L_L1(LL1), .ALPHA(ALP)) dut (
        .clk(clk), .rst_n(rst_n), .setup_i(setup_i), .mode_i(mode_i), .start_i(start_i),
        .slot_avail_o(slot_avail_o), .write_en_o(write_en_o), .wr_base_o(wr_base_o),
        .a_addr_o(a_addr_o), .b_addr_o(b_addr_o), .rst_t_o(rst_t_o), .rst_d_o(rst_d_o),
        .l2_en_o(l2_en_o), .l3_en_o(l3_en_o), .data_avail_o(data_avail_o));

    always #4 clk = ~clk;

    int checks = 0, fails = 0, n_acc = 0, n_dav = 0;
    bit done = 0, cmp_on = 0;

    // reference model (slot-indexed, no rotation)
    int m_st = 0, m_mode = 0, m_wd = 0, m_cur = 0;
    int m_occ [3], m_iter [3], m_aptr [3];
    bit m_avail = 0, m_cc = 0, m_fp = 1, m_we = 0, m_ign = 0;
    int m_wrb = 0;
    logic [31:0] we_h = 0, comp_h = 0, dav_h = 0, rd_h = 0;

    always @(posedge clk) begin
        int s, sg, nxt;
        bit comp, lastit, last, acc, onext, anyo;
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_wd = 0; m_cur = 0; m_avail = 0; m_cc = 0; m_fp = 1;
            m_we = 0; m_wrb = 0; m_ign = 0; we_h = 0; comp_h = 0; dav_h = 0; rd_h = 0;
            for (int i = 0; i < 3; i++) begin m_occ[i] = 0; m_iter[i] = 0; m_aptr[i] = 0; end
        end else begin
            s  = (m_mode != 0) ? 3 : 2;
            sg = (m_mode != 0) ? 2 : 3;
            comp   = (m_st != 0) && m_cc && (m_wd == 0);
            lastit = (m_iter[m_cur] == s - 1);
            we_h   = {we_h[30:0], m_we};
            comp_h = {comp_h[30:0], comp};
            dav_h  = {dav_h[30:0], comp && lastit};
            rd_h   = {rd_h[30:0], comp && m_fp};
            if (m_st == 0) begin
                m_mode = int'(mode_i);
                for (int i = 0; i < 3; i++) begin m_occ[i] = 0; m_iter[i] = 0; end
                m_wd = 0; m_cur = 0; m_cc = 0; m_fp = 1; m_we = 0; m_ign = 0;
                m_avail = !setup_i;
                m_st = setup_i ? 0 : 1;
            end else begin
                last = (m_wd == s - 1);
                acc  = m_avail && start_i;
                m_ign = start_i && !m_avail;
                nxt  = (m_cur + 1) % sg;
                onext = m_occ[nxt] != 0;
                anyo = (m_occ[0] != 0) || (m_occ[1] != 0) || (m_occ[2] != 0);
                m_we = acc;
                if (acc) begin m_wrb = m_cur * 2 * s; n_acc++; end
                if (comp) m_fp = 0;
                if (acc) begin m_occ[m_cur] = 1; m_iter[m_cur] = 0; m_aptr[m_cur] = m_cur * 2 * s; end
                if (last && m_cc) begin
                    if (lastit) begin m_occ[m_cur] = 0; m_iter[m_cur] = 0; end
                    else begin m_iter[m_cur]++; m_aptr[m_cur]++; end
                end
                if (m_st == 1) m_avail = last ? (!setup_i && !onext) : (acc ? 1'b0 : m_avail);
                else           m_avail = 0;
                if (last) begin m_cc = onext; m_cur = nxt; m_wd = 0; end
                else m_wd++;
                if (m_st == 1 && last && setup_i) m_st = 2;
                else if (m_st == 2 && !anyo) m_st = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int s;
        if (cmp_on) begin
            s = (m_mode != 0) ? 3 : 2;
            if (data_avail_o) n_dav++;
            chk((m_st == 2) ? "R12 slot_avail in drain" : "R2 slot_avail", slot_avail_o, m_avail);
            chk(m_ign ? "R4 ignored start write_en" : "R3 write_en", write_en_o, m_we);
            if (m_we) chk("R6 wr_base", wr_base_o, m_wrb);
            if (m_st != 0 && m_cc) begin
                chk("R7 a_addr", a_addr_o, m_aptr[m_cur]);
                chk("R7 b_addr", b_addr_o, m_cur * 2 * s + s + m_wd);
            end
            chk("R8 rst_t", rst_t_o, we_h[D_RT-1]);
            chk("R9 l2_en", l2_en_o, comp_h[D_L2-1]);
            chk("R9 l3_en", l3_en_o, comp_h[D_L3-1]);
            chk("R10 data_avail", data_avail_o, dav_h[D_DAV-1]);
            chk("R11 rst_d", rst_d_o, rd_h[D_RD-1]);
        end
    end

    task automatic drain_to_setup(input bit new_mode);
        @(negedge clk); setup_i = 1; start_i = 0; mode_i = new_mode;
        for (int k = 0; k < 500 && m_st != 0; k++) @(negedge clk);
        chk("R12 reached setup after drain", m_st, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset slot_avail", slot_avail_o, 0);
        chk("R1 reset write_en", write_en_o, 0);
        chk("R1 reset strobes", {rst_t_o, rst_d_o, l2_en_o, l3_en_o, data_avail_o}, 0);
        cmp_on = 1;
        // mode 0: saturating burst then sparse starts
        setup_i = 0;
        for (int n = 0; n < 220; n++) begin
            start_i = (n < 30) ? 1'b1 : (((n * 5) % 7) == 0);
            @(negedge clk);
        end
        drain_to_setup(1'b1);
        repeat (2) @(negedge clk);
        // mode 1: periodic starts
        setup_i = 0;
        for (int n = 0; n < 200; n++) begin
            start_i = (n % 3) == 1;
            @(negedge clk);
        end
        drain_to_setup(1'b0);
        @(negedge clk);
        // mode 0 again: dense pattern with holes
        setup_i = 0;
        for (int n = 0; n < 150; n++) begin
            start_i = (n % 4) != 0;
            @(negedge clk);
        end
        drain_to_setup(1'b0);
        repeat (30) @(negedge clk);
        chk("R5 one data_avail per booked job", n_dav, n_acc);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule